// File: doc/BRIEF.md
# Masked Vector Execution Unit

This unit holds a small bank of vector registers together with a per-element mask. It carries out one element-wise vector instruction at a time. An instruction is presented on a command port with an opcode, two source register indices, a destination register index and a 16-bit scalar. The unit then steps through the elements one per clock, starting at element 0.

A compare instruction rewrites the mask: each bit records whether the matching element of the source vector differs from the scalar. Later add and subtract instructions write only the destination elements whose mask bit is 1. Elements whose bit is 0 keep their old contents, but they still use their clock cycle. A clear instruction restores the mask to all ones. A host reaches the registers through a combinational read path and a single-element write path, and a one-cycle done pulse marks the end of each instruction.

Top module: `vmask_exec`

## Requirements
- R1: After reset the mask is all ones, every register element reads 0, `done` is low and `cmd_ready` is high.
- R2: Opcode 2'b00 (add) writes dst[i] = a[i] + b[i] modulo 2^16 for every element i whose mask bit is 1.
- R3: Opcode 2'b01 (subtract) writes dst[i] = a[i] - b[i] modulo 2^16 for every element i whose mask bit is 1.
- R4: During add or subtract, a destination element whose mask bit is 0 keeps its previous value, and the mask itself does not change.
- R5: Opcode 2'b10 (compare) sets mask bit i to 1 when a[i] differs from the scalar and to 0 when they are equal. The previous mask has no influence on the result.
- R6: Opcode 2'b11 (clear) leaves all mask bits at 1 when it completes. When no instruction runs, the mask does not change.
- R7: `done` pulses for exactly one cycle, 64 cycles after the clock edge that accepts a command. This holds for every opcode, including an add in which every element is masked off.
- R8: `cmd_ready` is low from the accepting edge until `done` is raised. A command held on the port during that time is not accepted until the unit is free again.
- R9: A host write (`rf_wr_en`) lands at the next edge while the unit is idle and is ignored while an instruction runs.
- R10: A destination register that is also a source register gives the same element-wise result as separate registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Opcode: 00 add, 01 subtract, 10 compare, 11 clear |
| cmd_src_a | input | 2 | First source register |
| cmd_src_b | input | 2 | Second source register |
| cmd_dst | input | 2 | Destination register |
| cmd_scalar | input | 16 | Scalar operand for compare |
| cmd_ready | output | 1 | Unit idle, command will be accepted |
| done | output | 1 | One-cycle end-of-instruction pulse |
| rf_wr_en | input | 1 | Host element write strobe |
| rf_wr_sel | input | 2 | Host write register |
| rf_wr_idx | input | 6 | Host write element |
| rf_wr_data | input | 16 | Host write data |
| rf_rd_sel | input | 2 | Host read register |
| rf_rd_idx | input | 6 | Host read element |
| rf_rd_data | output | 16 | Combinational host read data |
| mask_out | output | 64 | Current mask, bit i for element i |

## Verification
The assertions assume that a command counts as accepted only on an edge where `cmd_valid` and `cmd_ready` are both high, and that reset is held from time zero until the clocks are running. The bench drives every input half a cycle away from the active edge. It compares the register contents and the mask with its reference model only while the unit is idle, because intermediate element states are not part of the contract. The stimulus also holds commands and host writes on the ports while the unit is busy. This checks that they are refused, not that they are merely never presented.

// File: rtl/vmask_exec.sv
module vmask_exec #(
  parameter int NREG = 4,
  parameter int VLEN = 64,
  parameter int EW   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [1:0]              cmd_op,
  input  logic [$clog2(NREG)-1:0] cmd_src_a,
  input  logic [$clog2(NREG)-1:0] cmd_src_b,
  input  logic [$clog2(NREG)-1:0] cmd_dst,
  input  logic [EW-1:0]           cmd_scalar,
  output logic                    cmd_ready,
  output logic                    done,
  input  logic                    rf_wr_en,
  input  logic [$clog2(NREG)-1:0] rf_wr_sel,
  input  logic [$clog2(VLEN)-1:0] rf_wr_idx,
  input  logic [EW-1:0]           rf_wr_data,
  input  logic [$clog2(NREG)-1:0] rf_rd_sel,
  input  logic [$clog2(VLEN)-1:0] rf_rd_idx,
  output logic [EW-1:0]           rf_rd_data,
  output logic [VLEN-1:0]         mask_out
);
  localparam int RW = $clog2(NREG);
  localparam int IW = $clog2(VLEN);
  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_SUB = 2'b01;
  localparam logic [1:0] OP_SNE = 2'b10;
  localparam logic [1:0] OP_CLR = 2'b11;

  logic [EW-1:0]   vr [NREG][VLEN];
  logic [VLEN-1:0] mask;
  logic            busy;
  logic [IW-1:0]   idx;
  logic [1:0]      op_q;
  logic [RW-1:0]   sa, sb, sd;
  logic [EW-1:0]   scal;

  wire [EW-1:0] ea   = vr[sa][idx];
  wire [EW-1:0] eb   = vr[sb][idx];
  wire [EW-1:0] res  = (op_q == OP_SUB) ? ea - eb : ea + eb;
  wire          last = (idx == IW'(VLEN - 1));

  assign cmd_ready  = !busy;
  assign rf_rd_data = vr[rf_rd_sel][rf_rd_idx];
  assign mask_out   = mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
      op_q <= OP_ADD;
      sa   <= '0;
      sb   <= '0;
      sd   <= '0;
      scal <= '0;
      mask <= '1;
      for (int r = 0; r < NREG; r++)
        for (int i = 0; i < VLEN; i++)
          vr[r][i] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (rf_wr_en)
          vr[rf_wr_sel][rf_wr_idx] <= rf_wr_data;
        if (cmd_valid) begin
          busy <= 1'b1;
          idx  <= '0;
          op_q <= cmd_op;
          sa   <= cmd_src_a;
          sb   <= cmd_src_b;
          sd   <= cmd_dst;
          scal <= cmd_scalar;
        end
      end else begin
        case (op_q)
          OP_ADD, OP_SUB: if (mask[idx]) vr[sd][idx] <= res;
          OP_SNE:         mask[idx] <= (ea != scal);
          OP_CLR:         mask[idx] <= 1'b1;
          default:        ;
        endcase
        idx <= idx + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vmask_exec_chk.sv
module vmask_exec_chk #(
  parameter int VLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic            cmd_ready,
  input logic            done,
  input logic [VLEN-1:0] mask_out
);
  localparam int CW = $clog2(VLEN) + 1;

  logic          run;
  logic [CW-1:0] cnt;
  logic [1:0]    op_q;
  wire           take = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cnt  <= '0;
      op_q <= 2'b00;
    end else if (take) begin
      run  <= 1'b1;
      cnt  <= '0;
      op_q <= cmd_op;
    end else if (run) begin
      if (done) run <= 1'b0;
      else      cnt <= cnt + 1'b1;
    end
  end

  AST_DONE_AT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run && cnt == CW'(VLEN))); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_REFUSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done) |-> !cmd_ready); // R8
  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == 2'b11) |-> (&mask_out)); // R6
  AST_MASK_ARITH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done && !op_q[1]) |=> $stable(mask_out)); // R4
  AST_MASK_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !take) |=> $stable(mask_out)); // R6
endmodule

bind vmask_exec vmask_exec_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_ready(cmd_ready), .done(done), .mask_out(mask_out)
);

// File: tb/vmask_exec_bench.sv
`timescale 1ns/1ps
module vmask_exec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [1:0]  cmd_src_a = 2'd0, cmd_src_b = 2'd0, cmd_dst = 2'd0;
  logic [15:0] cmd_scalar = 16'd0;
  logic        cmd_ready, done;
  logic        rf_wr_en = 1'b0;
  logic [1:0]  rf_wr_sel = 2'd0;
  logic [5:0]  rf_wr_idx = 6'd0;
  logic [15:0] rf_wr_data = 16'd0;
  logic [1:0]  rf_rd_sel = 2'd0;
  logic [5:0]  rf_rd_idx = 6'd0;
  logic [15:0] rf_rd_data;
  logic [63:0] mask_out;

  vmask_exec u_vmask_exec (.*);

  always #4 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  string phase = "R1 reset";

  logic [15:0] m_vr [4][64];
  logic [63:0] m_mask;
  logic        m_busy, m_done;
  int          m_cnt;
  logic [1:0]  m_op, m_a, m_b, m_d;
  logic [15:0] m_s;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_mask = '1;
      for (int r = 0; r < 4; r++)
        for (int i = 0; i < 64; i++) m_vr[r][i] = 16'd0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 64) begin
          for (int i = 0; i < 64; i++) begin
            case (m_op)
              2'b00: if (m_mask[i]) m_vr[m_d][i] = m_vr[m_a][i] + m_vr[m_b][i];
              2'b01: if (m_mask[i]) m_vr[m_d][i] = m_vr[m_a][i] - m_vr[m_b][i];
              2'b10: m_mask[i] = (m_vr[m_a][i] != m_s);
              default: m_mask[i] = 1'b1;
            endcase
          end
          m_busy = 0;
          m_done = 1;
        end
      end else begin
        if (rf_wr_en) m_vr[rf_wr_sel][rf_wr_idx] = rf_wr_data;
        if (cmd_valid) begin
          m_busy = 1; m_cnt = 0;
          m_op = cmd_op; m_a = cmd_src_a; m_b = cmd_src_b; m_d = cmd_dst; m_s = cmd_scalar;
        end
      end
    end
    #6;
    if (rst_n) begin
      chk({phase, " R7 done"}, 64'(done), 64'(m_done));
      chk({phase, " R8 ready"}, 64'(cmd_ready), 64'(!m_busy));
      if (!m_busy) begin
        chk({phase, " mask"}, mask_out, m_mask);
        chk({phase, " data"}, 64'(rf_rd_data), 64'(m_vr[rf_rd_sel][rf_rd_idx]));
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [1:0] a, input logic [1:0] b,
                       input logic [1:0] d, input logic [15:0] s);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_src_a = a; cmd_src_b = b; cmd_dst = d; cmd_scalar = s;
    @(negedge clk);
    cmd_valid = 0;
    while (!done) @(negedge clk);
  endtask

  task automatic sweep();
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        rf_rd_sel = 2'(r); rf_rd_idx = 6'(i);
      end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mask reset", mask_out, '1);
    chk("R1 done reset", 64'(done), 64'd0);
    chk("R1 ready reset", 64'(cmd_ready), 64'd1);
    chk("R1 data reset", 64'(rf_rd_data), 64'd0);
    rst_n = 1;
    sweep();

    phase = "R9 load";
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        rf_wr_en = 1; rf_wr_sel = 2'(r); rf_wr_idx = 6'(i);
        rf_wr_data = (r == 0 && i % 5 == 0) ? 16'h0055 : 16'((r * 977 + i * 4133 + 7) ^ (i << 9));
      end
    @(negedge clk);
    rf_wr_en = 0;
    sweep();

    phase = "R2 add all-ones";
    issue(2'b00, 2'd0, 2'd1, 2'd2, 16'd0);
    sweep();

    phase = "R5 compare";
    issue(2'b10, 2'd0, 2'd0, 2'd0, 16'h0055);
    chk("R5 mask pattern bit0", 64'(mask_out[0]), 64'd0);
    chk("R5 mask pattern bit1", 64'(mask_out[1]), 64'd1);

    phase = "R3 R4 masked sub";
    issue(2'b01, 2'd1, 2'd3, 2'd2, 16'd0);
    sweep();

    phase = "R10 alias add";
    issue(2'b00, 2'd3, 2'd1, 2'd3, 16'd0);
    sweep();

    phase = "R8 held command";
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'b00; cmd_src_a = 2'd1; cmd_src_b = 2'd1; cmd_dst = 2'd0; cmd_scalar = 0;
    @(negedge clk);
    cmd_op = 2'b01; cmd_dst = 2'd3;
    phase = "R9 write while busy";
    rf_wr_en = 1; rf_wr_sel = 2'd1; rf_wr_idx = 6'd5; rf_wr_data = 16'hBEEF;
    @(negedge clk);
    rf_wr_en = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    while (!done) @(negedge clk);
    sweep();

    phase = "R5 compare ignores mask";
    issue(2'b10, 2'd2, 2'd0, 2'd0, 16'h1234);
    sweep();

    phase = "R6 clear";
    issue(2'b11, 2'd0, 2'd0, 2'd0, 16'd0);
    chk("R6 all ones", mask_out, '1);

    phase = "R7 all masked add";
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      rf_wr_en = 1; rf_wr_sel = 2'd3; rf_wr_idx = 6'(i); rf_wr_data = 16'h00AA;
    end
    @(negedge clk);
    rf_wr_en = 0;
    issue(2'b10, 2'd3, 2'd0, 2'd0, 16'h00AA);
    chk("R5 all equal gives zero mask", mask_out, 64'd0);
    issue(2'b00, 2'd1, 2'd2, 2'd0, 16'd0);
    sweep();
    issue(2'b11, 2'd0, 2'd0, 2'd0, 16'd0);
    issue(2'b01, 2'd2, 2'd0, 2'd1, 16'd0);
    sweep();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule